// File: doc/BRIEF.md
# Memory PHY Reset Sequencer

This block runs the power-up bring-up of a DDR memory PHY once a start pulse arrives. It steps through a fixed, ordered chain of actions. The memory clock is held low and the PHY is reset. The output drivers are flushed and the impedance controller is run. The DLLs are released, and the clock-alignment circuit is run until it locks. The sysclk reset is then released, a fixed control word is written, and the block waits a settle time. Each timed step has a guaranteed minimum width in clock cycles. Each step that waits on the analog side polls a status input, and a programmable cycle limit bounds that poll.

The sequence ends in one of two ways. If it runs to the end, or if a poll expires, the block samples the fault-indication input and then finishes. It reports done together with a result code. The fault-unmask pulse is issued only on a fully clean finish. With no memory modules populated, the block finishes at once and leaves the PHY untouched.

Top module: `phy_rst_seq`

## Requirements
- R1: A start with `dimm_cnt` equal to zero gives `done`=1 and `err_code`=0 on the next cycle. No PHY control output leaves its idle value, and `fault_unmask` stays low.
- R2: `mclk_force_low` rises on the cycle after an accepted start. It stays high through every step. It falls exactly 32 cycles after the single `align_wr` cycle.
- R3: `phy_reset` is high for exactly 32 consecutive cycles, as one pulse, before any later step begins.
- R4: `flush` and `init_io` are high together, never apart, for exactly 32 cycles, after the PHY reset and before the impedance step.
- R5: `zctl_en` is high for exactly 1024 cycles. Polling of `zcal_done` then begins. The poll spends at most `tmo_limit`+1 cycles: a `zcal_done` first seen on poll cycle k (0-based, k ≤ `tmo_limit`) passes. Otherwise the poll expires with code 1.
- R6: `dll_cal_rst` (1 = held in reset) drops after the impedance step. The block then waits until both `dll_adr_stat` and `dll_dat_stat` (3 bits each) have at least one bit set. The same timeout rule as R5 applies, with code 2.
- R7: `align_cont` stays high for 5932 cycles plus the lock poll. The lock poll needs `lock_adr` and `lock_dat` both high and follows the R5 timeout rule, with code 3. On success `align_cont` is therefore high for 5932+k+1 cycles.
- R8: After lock, `sysclk_rst` (1 = reset) drops first. On a later cycle `align_wr` pulses for one cycle with `align_word`=0x8020.
- R9: At the end of the sequence, and also after an expired poll, `fault_seen` captures `fault_in`. A fault with no expired poll gives code 4. `fault_unmask` pulses for one cycle only when the code is 0.
- R10: A start while `busy` is ignored. `done` and `err_code` hold until the next start.
- R11: After reset: `busy`=0, `done`=0, `phy_reset`=0, `mclk_force_low`=0, `sysclk_rst`=1, `dll_cal_rst`=1, `fault_unmask`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| dimm_cnt | input | DIMM_W | Number of populated memory modules |
| tmo_limit | input | TMO_W | Poll timeout limit (poll lasts at most limit+1 cycles) |
| zcal_done | input | 1 | Impedance calibration finished |
| dll_adr_stat | input | 3 | Address-lane DLL status bits |
| dll_dat_stat | input | 3 | Data-lane DLL status bits |
| lock_adr | input | 1 | Address-lane clock alignment locked |
| lock_dat | input | 1 | Data-lane clock alignment locked |
| fault_in | input | 1 | Fault indication from the PHY |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished, held until next start |
| err_code | output | 3 | 0 ok, 1 impedance timeout, 2 DLL timeout, 3 lock timeout, 4 fault |
| fault_seen | output | 1 | Fault input sampled at the end check |
| mclk_force_low | output | 1 | Hold the memory clock low |
| phy_reset | output | 1 | PHY reset |
| flush | output | 1 | Output-driver flush |
| init_io | output | 1 | IO init, paired with flush |
| zctl_en | output | 1 | Impedance controller enable |
| dll_cal_rst | output | 1 | DLL calibration held in reset |
| align_cont | output | 1 | Clock alignment in continuous update |
| sysclk_rst | output | 1 | Sysclk alignment reset |
| align_wr | output | 1 | Alignment control word write strobe |
| align_word | output | WORD_W | Alignment control word |
| fault_unmask | output | 1 | One-cycle fault unmask pulse |

## Verification
The hardest cases are the poll boundaries. Status must arrive on exactly the last allowed poll cycle, or one cycle after it, and each poll begins only after thousands of cycles of fixed waits. The bench does not predict those start cycles. It finds the start of each poll from the falling or rising edge of the preceding output: `zctl_en` falling, `dll_cal_rst` falling, or `align_cont` rising. It then raises the status a chosen number of cycles later. Directed runs hit offsets equal to the limit and the limit plus one. Random runs mix the limits, offsets, lane patterns and fault levels. One directed run combines an expired poll with a fault, so that the fault check on the error exit is exercised.

// File: rtl/phyrst_pkg.sv
// Shared types for the PHY reset sequencer: step encoding and result codes.
package phyrst_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_PREP, S_RST, S_FLUSH, S_ZCTL, S_ZPOLL, S_DLL, S_ALIGN,
        S_LOCK, S_SYSREL, S_WORD, S_SETTLE, S_CHECK, S_UNMASK, S_FIN
    } seq_st_e;

    typedef enum logic [2:0] {
        E_NONE  = 3'd0,
        E_ZCAL  = 3'd1,
        E_DLL   = 3'd2,
        E_LOCK  = 3'd3,
        E_FAULT = 3'd4
    } seq_err_e;
endpackage

// File: rtl/phy_step_timer.sv
// Step timer: counts cycles spent in the current step and flags the limit.
// Assumes the controller pulses clear on every step change, so the count is
// 0 on the first cycle of each step. It saturates rather than wrapping.
module phy_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit
);
    logic [CNT_W-1:0] cnt_q;

    // Cycle count within the step, restarted at each step change.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clear)          cnt_q <= '0;
        else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
    end

    // Terminal flag for the step currently selected.
    always_comb at_limit = (cnt_q == limit);
endmodule

// File: rtl/phy_seq_decode.sv
// Output decoder: maps the controller step and the two release flags onto
// the PHY control pins. It is purely combinational, so every pin changes on
// the same edge as the step register.
module phy_seq_decode
    import phyrst_pkg::*;
#(
    parameter int                 WORD_W    = 16,
    parameter logic [WORD_W-1:0]  CTRL_WORD = 16'h8020
) (
    input  seq_st_e           st,
    input  logic              dll_rel,
    input  logic              sys_rel,
    output logic              busy,
    output logic              done,
    output logic              mclk_force_low,
    output logic              phy_reset,
    output logic              flush,
    output logic              init_io,
    output logic              zctl_en,
    output logic              dll_cal_rst,
    output logic              align_cont,
    output logic              sysclk_rst,
    output logic              align_wr,
    output logic [WORD_W-1:0] align_word,
    output logic              fault_unmask
);
    // Step-driven pin levels; everything idles when not selected.
    always_comb begin
        busy           = !(st inside {S_IDLE, S_FIN});
        done           = (st == S_FIN);
        mclk_force_low = busy && !(st inside {S_CHECK, S_UNMASK});
        phy_reset      = (st == S_RST);
        flush          = (st == S_FLUSH);
        init_io        = (st == S_FLUSH);
        zctl_en        = (st == S_ZCTL);
        dll_cal_rst    = !dll_rel;
        align_cont     = (st inside {S_ALIGN, S_LOCK});
        sysclk_rst     = !sys_rel;
        align_wr       = (st == S_WORD);
        align_word     = (st == S_WORD) ? CTRL_WORD : '0;
        fault_unmask   = (st == S_UNMASK);
    end
endmodule

// File: rtl/phy_rst_seq.sv
// PHY reset sequencer top. After an accepted start, it holds the memory clock
// low and then steps through these actions in order: PHY reset, driver
// flush, impedance calibration, DLL release, clock alignment with lock poll,
// sysclk release, control-word write and settle. Every poll is bounded by
// tmo_limit. The fault input is checked on both exits, and unmask is pulsed
// only on a clean finish. The status inputs are assumed to be synchronous
// to clk.
module phy_rst_seq
    import phyrst_pkg::*;
#(
    parameter int                RST_CYC    = 32,
    parameter int                FLUSH_CYC  = 32,
    parameter int                ZQ_CYC     = 1024,
    parameter int                ALIGN_CYC  = 5932,
    parameter int                SETTLE_CYC = 32,
    parameter int                TMO_W      = 16,
    parameter int                DIMM_W     = 3,
    parameter int                WORD_W     = 16,
    parameter logic [WORD_W-1:0] CTRL_WORD  = 16'h8020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIMM_W-1:0] dimm_cnt,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              zcal_done,
    input  logic [2:0]        dll_adr_stat,
    input  logic [2:0]        dll_dat_stat,
    input  logic              lock_adr,
    input  logic              lock_dat,
    input  logic              fault_in,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic              fault_seen,
    output logic              mclk_force_low,
    output logic              phy_reset,
    output logic              flush,
    output logic              init_io,
    output logic              zctl_en,
    output logic              dll_cal_rst,
    output logic              align_cont,
    output logic              sysclk_rst,
    output logic              align_wr,
    output logic [WORD_W-1:0] align_word,
    output logic              fault_unmask
);
    localparam int AW    = $clog2(ALIGN_CYC + 1);
    localparam int CNT_W = (TMO_W > AW) ? TMO_W : AW;

    seq_st_e          st_q, st_d;
    seq_err_e         err_q, err_d;
    logic             fault_q, fault_d;
    logic             dll_rel_q, dll_rel_d;
    logic             sys_rel_q, sys_rel_d;
    logic [CNT_W-1:0] lim;
    logic             at_lim;
    logic             step_chg;

    // Limit for the current step: a fixed width or the poll timeout.
    always_comb begin
        case (st_q)
            S_RST:    lim = CNT_W'(RST_CYC - 1);
            S_FLUSH:  lim = CNT_W'(FLUSH_CYC - 1);
            S_ZCTL:   lim = CNT_W'(ZQ_CYC - 1);
            S_ALIGN:  lim = CNT_W'(ALIGN_CYC - 1);
            S_SETTLE: lim = CNT_W'(SETTLE_CYC - 1);
            default:  lim = CNT_W'(tmo_limit);
        endcase
    end

    phy_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (step_chg),
        .limit    (lim),
        .at_limit (at_lim)
    );

    // Step sequencing, result code and fault capture.
    always_comb begin
        st_d    = st_q;
        err_d   = err_q;
        fault_d = fault_q;
        case (st_q)
            S_IDLE, S_FIN: if (start) begin
                err_d   = E_NONE;
                fault_d = 1'b0;
                st_d    = (dimm_cnt == '0) ? S_FIN : S_PREP;
            end
            S_PREP:   st_d = S_RST;
            S_RST:    if (at_lim) st_d = S_FLUSH;
            S_FLUSH:  if (at_lim) st_d = S_ZCTL;
            S_ZCTL:   if (at_lim) st_d = S_ZPOLL;
            S_ZPOLL:
                if (zcal_done) st_d = S_DLL;
                else if (at_lim) begin err_d = E_ZCAL; st_d = S_CHECK; end
            S_DLL:
                if ((|dll_adr_stat) && (|dll_dat_stat)) st_d = S_ALIGN;
                else if (at_lim) begin err_d = E_DLL; st_d = S_CHECK; end
            S_ALIGN:  if (at_lim) st_d = S_LOCK;
            S_LOCK:
                if (lock_adr && lock_dat) st_d = S_SYSREL;
                else if (at_lim) begin err_d = E_LOCK; st_d = S_CHECK; end
            S_SYSREL: st_d = S_WORD;
            S_WORD:   st_d = S_SETTLE;
            S_SETTLE: if (at_lim) st_d = S_CHECK;
            S_CHECK: begin
                fault_d = fault_in;
                if (err_q != E_NONE) st_d = S_FIN;
                else if (fault_in) begin err_d = E_FAULT; st_d = S_FIN; end
                else st_d = S_UNMASK;
            end
            S_UNMASK: st_d = S_FIN;
            default:  st_d = S_IDLE;
        endcase
    end

    // Release flags: cleared by a new start, set on entering their step.
    always_comb begin
        step_chg  = (st_d != st_q);
        dll_rel_d = dll_rel_q;
        sys_rel_d = sys_rel_q;
        if ((st_q inside {S_IDLE, S_FIN}) && start) begin
            dll_rel_d = 1'b0;
            sys_rel_d = 1'b0;
        end
        if (st_d == S_DLL)    dll_rel_d = 1'b1;
        if (st_d == S_SYSREL) sys_rel_d = 1'b1;
    end

    // Controller state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            err_q     <= E_NONE;
            fault_q   <= 1'b0;
            dll_rel_q <= 1'b0;
            sys_rel_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            err_q     <= err_d;
            fault_q   <= fault_d;
            dll_rel_q <= dll_rel_d;
            sys_rel_q <= sys_rel_d;
        end
    end

    phy_seq_decode #(.WORD_W(WORD_W), .CTRL_WORD(CTRL_WORD)) u_dec (
        .st             (st_q),
        .dll_rel        (dll_rel_q),
        .sys_rel        (sys_rel_q),
        .busy           (busy),
        .done           (done),
        .mclk_force_low (mclk_force_low),
        .phy_reset      (phy_reset),
        .flush          (flush),
        .init_io        (init_io),
        .zctl_en        (zctl_en),
        .dll_cal_rst    (dll_cal_rst),
        .align_cont     (align_cont),
        .sysclk_rst     (sysclk_rst),
        .align_wr       (align_wr),
        .align_word     (align_word),
        .fault_unmask   (fault_unmask)
    );

    // Result outputs.
    always_comb begin
        err_code   = err_q;
        fault_seen = fault_q;
    end

    AST_ZERO_DIMM: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && dimm_cnt == '0) |=> (done && !mclk_force_low && err_code == 3'd0)); // R1
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phy_reset, flush, zctl_en, align_cont, align_wr})); // R3
    AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        align_wr |-> (!sysclk_rst && $past(!sysclk_rst) && mclk_force_low && align_word == CTRL_WORD)); // R8
    AST_UNMASK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fault_unmask |=> (done && err_code == 3'd0 && !fault_seen)); // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_force_low) |-> $past(!busy)); // R10
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_code))); // R10
endmodule

// File: tb/tb_phy_rst_seq.sv
// Self-checking bench for phy_rst_seq: directed poll-boundary cases plus
// seeded random runs, with status inputs timed from observed output edges.
module tb_phy_rst_seq;
    localparam int ALIGN = 5932;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  dimm_cnt = 3'd2;
    logic [15:0] tmo_limit = 16'd0;
    logic        zcal_done = 1'b0;
    logic [2:0]  dll_adr_stat = 3'd0;
    logic [2:0]  dll_dat_stat = 3'd0;
    logic        lock_adr = 1'b0;
    logic        lock_dat = 1'b0;
    logic        fault_in = 1'b0;
    logic        busy, done, fault_seen, mclk_force_low, phy_reset, flush, init_io;
    logic        zctl_en, dll_cal_rst, align_cont, sysclk_rst, align_wr, fault_unmask;
    logic [2:0]  err_code;
    logic [15:0] align_word;

    phy_rst_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dimm_cnt(dimm_cnt),
        .tmo_limit(tmo_limit), .zcal_done(zcal_done), .dll_adr_stat(dll_adr_stat),
        .dll_dat_stat(dll_dat_stat), .lock_adr(lock_adr), .lock_dat(lock_dat),
        .fault_in(fault_in), .busy(busy), .done(done), .err_code(err_code),
        .fault_seen(fault_seen), .mclk_force_low(mclk_force_low), .phy_reset(phy_reset),
        .flush(flush), .init_io(init_io), .zctl_en(zctl_en), .dll_cal_rst(dll_cal_rst),
        .align_cont(align_cont), .sysclk_rst(sysclk_rst), .align_wr(align_wr),
        .align_word(align_word), .fault_unmask(fault_unmask)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int cfg_zd, cfg_dd, cfg_ld, cfg_dmode;
    logic [2:0] oh_a, oh_d;
    bit z_arm, d_arm, a_arm, wr_seen, zprev, sys_prev;
    bit seen_rst, seen_flush, seen_zctl, seen_align, rst_prev;
    int zs, ds, as_c;
    int n_rst, n_rise, n_flush, n_mis, n_zctl, n_align, n_wr, n_word_bad;
    int n_sys_bad, n_settle, n_unmask, n_mclk, n_any, n_order;

    // Status emulation and output monitors, evaluated at falling edges.
    always @(negedge clk) begin
        cyc++;
        if (zprev && !zctl_en) begin z_arm = 1; zs = 0; end else if (z_arm) zs++;
        zcal_done = z_arm && zs >= cfg_zd;
        if (!d_arm && busy && !dll_cal_rst) begin d_arm = 1; ds = 0; end else if (d_arm) ds++;
        dll_adr_stat = (d_arm && ds >= cfg_dd && cfg_dmode != 2) ? oh_a : 3'd0;
        dll_dat_stat = (d_arm && ds >= cfg_dd && cfg_dmode != 1) ? oh_d : 3'd0;
        if (!a_arm && align_cont) begin a_arm = 1; as_c = 0; end else if (a_arm) as_c++;
        lock_adr = a_arm && as_c >= ALIGN + cfg_ld;
        lock_dat = lock_adr;
        if (phy_reset) n_rst++;
        if (phy_reset && !rst_prev) n_rise++;
        if (flush) n_flush++;
        if (flush != init_io) n_mis++;
        if (zctl_en) n_zctl++;
        if (align_cont) n_align++;
        if (mclk_force_low) n_mclk++;
        if (fault_unmask) n_unmask++;
        if (align_wr) begin
            n_wr++;
            if (align_word != 16'h8020) n_word_bad++;
            if (sys_prev) n_sys_bad++;
        end else if (wr_seen && mclk_force_low) n_settle++;
        if (align_wr) wr_seen = 1;
        if (phy_reset | flush | zctl_en | align_cont | align_wr | mclk_force_low |
            !dll_cal_rst | !sysclk_rst | fault_unmask) n_any++;
        if (flush && !seen_rst) n_order++;
        if (zctl_en && (!seen_flush || phy_reset)) n_order++;
        if (!dll_cal_rst && !seen_zctl) n_order++;
        if (align_cont && dll_cal_rst) n_order++;
        if (align_wr && !seen_align) n_order++;
        if (phy_reset) seen_rst = 1;
        if (flush) seen_flush = 1;
        if (zctl_en) seen_zctl = 1;
        if (align_cont) seen_align = 1;
        zprev = zctl_en; rst_prev = phy_reset; sys_prev = sysclk_rst;
    end

    task automatic tick();
        @(negedge clk); #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_err(int tmo, int zd, int dm, int dd, int ld, bit f);
        if (zd > tmo) return 1;
        if (dm == 1 || dm == 2 || dd > tmo) return 2;
        if (ld > tmo) return 3;
        return f ? 4 : 0;
    endfunction

    task automatic run_case(int dimm, int tmo, int zd, int dm, int dd, int ld, bit f, bit mid);
        int e, w;
        e = (dimm == 0) ? 0 : exp_err(tmo, zd, dm, dd, ld, f);
        tick();
        dimm_cnt = 3'(dimm); tmo_limit = 16'(tmo); fault_in = f;
        cfg_zd = zd; cfg_dd = dd; cfg_ld = ld; cfg_dmode = dm;
        oh_a = 3'b001 << ($urandom % 3); oh_d = 3'b001 << ($urandom % 3);
        z_arm = 0; d_arm = 0; a_arm = 0; wr_seen = 0;
        seen_rst = 0; seen_flush = 0; seen_zctl = 0; seen_align = 0;
        n_rst = 0; n_rise = 0; n_flush = 0; n_mis = 0; n_zctl = 0; n_align = 0; n_wr = 0;
        n_word_bad = 0; n_sys_bad = 0; n_settle = 0; n_unmask = 0; n_mclk = 0; n_any = 0; n_order = 0;
        start = 1;
        tick();
        start = 0;
        w = 0;
        while (!done && w < 9000) begin
            tick(); w++;
            start = (mid && w == 40);
        end
        start = 0;
        if (w >= 9000) chk("R10 watchdog", 0, 1);
        chk("R10 done", done, 1);
        chk("R5 R6 R7 R9 err_code", err_code, e);
        chk("R9 unmask count", n_unmask, (e == 0 && dimm != 0) ? 1 : 0);
        if (dimm == 0) begin
            chk("R1 untouched pins", n_any, 0);
        end else begin
            chk("R9 fault_seen", fault_seen, f);
            chk("R3 reset width", n_rst, 32);
            chk("R10 single reset pulse", n_rise, 1);
            chk("R4 flush width", n_flush, 32);
            chk("R4 flush/init_io paired", n_mis, 0);
            chk("R5 zctl width", n_zctl, 1024);
            chk("R3 step order", n_order, 0);
            if (e == 3) chk("R7 align on timeout", n_align, ALIGN + tmo + 1);
            if (e == 0 || e == 4) begin
                chk("R7 align width", n_align, ALIGN + ld + 1);
                chk("R8 word writes", n_wr, 1);
                chk("R8 word value", n_word_bad, 0);
                chk("R8 sysclk before write", n_sys_bad, 0);
                chk("R2 settle after write", n_settle, 32);
                chk("R2 clock held", n_mclk, 1 + 32 + 32 + 1024 + zd + 1 + dd + 1 + ALIGN + ld + 1 + 2 + 32);
            end
        end
        repeat (5) tick();
        chk("R10 done held", done, 1);
        chk("R10 code held", err_code, e);
    endtask

    initial begin
        void'($urandom(32'd1234));
        cfg_zd = 0; cfg_dd = 0; cfg_ld = 0; cfg_dmode = 0; oh_a = 1; oh_d = 1;
        repeat (3) tick();
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 phy_reset", phy_reset, 0);
        chk("R11 mclk", mclk_force_low, 0);
        chk("R11 sysclk_rst", sysclk_rst, 1);
        chk("R11 dll_cal_rst", dll_cal_rst, 1);
        chk("R11 unmask", fault_unmask, 0);
        rst_n = 1;
        run_case(2, 10, 3, 0, 0, 5, 0, 0);   // plain success
        run_case(0, 10, 0, 0, 0, 0, 0, 0);   // R1 no modules
        run_case(1, 5, 5, 0, 2, 1, 0, 0);    // R5 status on last poll cycle
        run_case(1, 5, 6, 0, 0, 0, 0, 0);    // R5 one cycle late
        run_case(3, 8, 0, 2, 0, 0, 0, 0);    // R6 data lane only
        run_case(3, 8, 0, 1, 0, 0, 1, 0);    // R6 address lane only, R9 fault on error exit
        run_case(2, 4, 0, 0, 4, 5, 0, 0);    // R7 lock one cycle late
        run_case(2, 4, 1, 0, 1, 4, 1, 0);    // R9 fault after clean steps
        run_case(2, 6, 2, 0, 2, 2, 0, 1);    // R10 start while busy
        run_case(1, 0, 0, 0, 0, 0, 0, 0);    // zero limit, immediate status
        for (int i = 0; i < 6; i++) begin
            int t;
            t = $urandom % 20;
            run_case(1 + ($urandom % 7), t, $urandom % 24, $urandom % 4,
                     $urandom % 24, $urandom % 24, ($urandom % 4) == 0, 0);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Global watchdog: a hung run is counted as a failure.
    initial begin
        wait (cyc > 190000);
        n_chk++; n_bad++;
        $display("FAIL R10 global watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule